// File: doc/BRIEF.md
# Stepped Clock Post-Divider with Glitch-Free Gating

The block takes a fast source clock and produces a divided clock at 50% duty cycle. A 2-bit ratio code selects a base division of 1, 2, 4 or 8. A power-down request multiplies the division by a further 16. That extra factor is not applied in one jump. It is walked up (and later back down) one doubling at a time. The steps are paced by a separate, slower reference clock, so the downstream load sees a gradual frequency change.

An output-enable input gates the clock. Every change of ratio, step or enable waits for the end of a complete output period, so the output never carries a runt or truncated pulse. When disabled, the output rests low. At a division of 1 the source clock itself is passed through, behind a gate that only opens or closes while the source clock is low.

The control inputs are treated as asynchronous and are synchronised into the clock domain that uses them. The power-down request goes into the reference domain. The ratio code, the current step and the enable go into the source domain.

Top module: `pds_top`

## Requirements
- R1: The ratio code `ratio_code[1:0]` selects the base division: 2'b11 divides by 1, 2'b00 by 2, 2'b01 by 4 and 2'b10 by 8.
- R2: With the output enabled and the settings stable, the output is high for exactly half of every output period at each division.
- R3: With `pwr_down` held high and settled, the output period is the base division times 16 source cycles.
- R4: Raising `pwr_down` moves the extra factor through 2, 4, 8 and 16 one doubling at a time. Lowering it halves the factor back through 8, 4, 2 and 1. No value is skipped, and the direction never reverses while the request is steady.
- R5: Each step takes effect no sooner than `PACE_REF` reference clock cycles after the previous one. The steps are counted on the reference clock, not on the source clock.
- R6: A change of `out_en` takes effect only at the end of a complete output period. Every high pulse and every low gap keeps its full half-period length.
- R7: While disabled, and during reset, `clk_out` is held at logic 0.
- R8: A change of the ratio code or of the power-down step takes effect only at the end of a complete output period. Every observed pulse and gap is a full half-period of either the old or the new division.
- R9: At a total division of 1, `clk_out` follows the source clock, high for the source clock's high phase and low for its low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast source clock to be divided |
| ref_clk | input | 1 | Slow reference clock that paces power-down steps |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ratio_code | input | 2 | Base division select (11:1, 00:2, 01:4, 10:8) |
| pwr_down | input | 1 | Request for the extra divide-by-16 |
| out_en | input | 1 | Output enable, active high |
| clk_out | output | 1 | Divided, gated clock output |

## Verification
A wrong divider count or a wrong loaded ratio shows at the port within one output period, as a wrong edge count or a wrong high/low split in a fixed sampling window. A wrong power-down step sequence shows as a skipped or reversed period in the logged period series, and it appears within one reference step interval. A step counter that is paced by the wrong clock shows as steps spaced far closer than the reference pacing. A boundary violation in the enable or ratio hand-over shows as a pulse or gap whose width is not a half-period of the old or the new division. It appears on the very first pulse after the change.

// File: rtl/pds_pkg.sv
`timescale 1ns/100ps
package pds_pkg;

    localparam int CODE_W      = 2;
    localparam int BASE_LG_MAX = 3;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;

    // base code to log2 of the base division: 11->0, 00->1, 01->2, 10->3
    function automatic logic [CODE_W-1:0] code_to_lg(input logic [CODE_W-1:0] code);
        return code + 2'd1;
    endfunction

endpackage

// File: rtl/pds_sync.sv
`timescale 1ns/100ps
module pds_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pds_stepper.sv
`timescale 1ns/100ps
module pds_stepper
    import pds_pkg::*;
#(
    parameter int STEPS = 4,
    parameter int PACE  = 1,
    parameter int SW    = 3
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic          pd_i,
    output logic [SW-1:0] step_o,
    output logic [SW-1:0] step_gray_o
);

    localparam int PW = (PACE > 1) ? $clog2(PACE) : 1;
    localparam logic [PW-1:0] PACE_LAST = PW'(PACE - 1);
    localparam logic [SW-1:0] STEP_TOP  = SW'(STEPS);

    typedef struct packed {
        logic [PW-1:0] pace;
        logic [SW-1:0] step;
        logic [SW-1:0] gray;
    } stp_t;

    stp_t      st_d, st_q;
    step_dir_e dir;

    always_comb begin
        st_d = st_q;
        dir  = STEP_HOLD;
        if (pd_i && st_q.step != STEP_TOP)
            dir = STEP_UP;
        else if (!pd_i && st_q.step != '0)
            dir = STEP_DOWN;

        if (dir == STEP_HOLD) begin
            st_d.pace = '0;
        end else if (st_q.pace == PACE_LAST) begin
            st_d.pace = '0;
            st_d.step = (dir == STEP_UP) ? st_q.step + 1'b1 : st_q.step - 1'b1;
        end else begin
            st_d.pace = st_q.pace + 1'b1;
        end
        st_d.gray = st_d.step ^ (st_d.step >> 1);
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_o      = st_q.step;
    assign step_gray_o = st_q.gray;

endmodule

// File: rtl/pds_divcore.sv
`timescale 1ns/100ps
module pds_divcore
    import pds_pkg::*;
#(
    parameter int SW    = 3,
    parameter int LG_W  = 3,
    parameter int CNT_W = 6
) (
    input  logic             src_clk,
    input  logic             rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic [SW-1:0]    step_gray_i,
    input  logic             en_i,
    output logic             div_out_o,
    output logic             pt_sel_o,
    output logic             pt_gate_o,
    output logic [LG_W-1:0]  lg_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             en_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [LG_W-1:0]  lg;
        logic             en;
        logic             phase;
        logic             out;
    } core_t;

    core_t            cr_d, cr_q;
    logic [SW-1:0]    step_bin;
    logic [LG_W-1:0]  lg_new;
    logic [CNT_W:0]   half_full;
    logic [CNT_W-1:0] half_m1;
    logic             boundary;
    logic             gate_q;

    always_comb begin
        for (int i = 0; i < SW; i++)
            step_bin[i] = ^(step_gray_i >> i);
    end

    assign lg_new    = LG_W'(code_to_lg(code_i)) + LG_W'(step_bin);
    assign half_full = (CNT_W+1)'(1) << (cr_q.lg - LG_W'(1));
    assign half_m1   = CNT_W'(half_full - 1'b1);

    always_comb begin
        cr_d     = cr_q;
        boundary = 1'b0;
        if (cr_q.lg == '0) begin
            boundary = 1'b1;
        end else if (cr_q.cnt == half_m1) begin
            cr_d.cnt   = '0;
            cr_d.phase = ~cr_q.phase;
            boundary   = ~cr_q.phase;
        end else begin
            cr_d.cnt = cr_q.cnt + 1'b1;
        end

        if (boundary) begin
            cr_d.lg    = lg_new;
            cr_d.en    = en_i;
            cr_d.cnt   = '0;
            cr_d.phase = 1'b1;
        end
        cr_d.out = (cr_d.lg != '0) && cr_d.phase && cr_d.en;
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    // pass-through gate only moves while the source clock is low
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= (cr_q.lg == '0) && cr_q.en;
    end

    assign div_out_o = cr_q.out;
    assign pt_sel_o  = (cr_q.lg == '0);
    assign pt_gate_o = gate_q;
    assign lg_o      = cr_q.lg;
    assign cnt_o     = cr_q.cnt;
    assign en_o      = cr_q.en;

endmodule

// File: rtl/pds_top.sv
`timescale 1ns/100ps
module pds_top
    import pds_pkg::*;
#(
    parameter int STEPS       = 4,
    parameter int PACE_REF    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              pwr_down,
    input  logic              out_en,
    output logic              clk_out
);

    localparam int SW     = $clog2(STEPS + 1);
    localparam int LG_MAX = BASE_LG_MAX + STEPS;
    localparam int LG_W   = $clog2(LG_MAX + 1);
    localparam int CNT_W  = (LG_MAX > 1) ? LG_MAX - 1 : 1;

    logic              pd_ref;
    logic [SW-1:0]     ref_step;
    logic [SW-1:0]     ref_gray;
    logic [SW-1:0]     src_gray;
    logic [CODE_W:0]   src_ctl;
    logic              div_out;
    logic              pt_sel;
    logic              pt_gate;
    logic [LG_W-1:0]   core_lg;
    logic [CNT_W-1:0]  core_cnt;
    logic              core_en;

    pds_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pd_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(pwr_down), .q(pd_ref)
    );

    pds_stepper #(.STEPS(STEPS), .PACE(PACE_REF), .SW(SW)) u_stepper (
        .ref_clk(ref_clk), .rst_n(rst_n), .pd_i(pd_ref),
        .step_o(ref_step), .step_gray_o(ref_gray)
    );

    pds_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_step_sync (
        .clk(src_clk), .rst_n(rst_n), .d(ref_gray), .q(src_gray)
    );

    pds_sync #(.W(CODE_W+1), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk(src_clk), .rst_n(rst_n), .d({out_en, ratio_code}), .q(src_ctl)
    );

    pds_divcore #(.SW(SW), .LG_W(LG_W), .CNT_W(CNT_W)) u_core (
        .src_clk(src_clk), .rst_n(rst_n),
        .code_i(src_ctl[CODE_W-1:0]), .step_gray_i(src_gray), .en_i(src_ctl[CODE_W]),
        .div_out_o(div_out), .pt_sel_o(pt_sel), .pt_gate_o(pt_gate),
        .lg_o(core_lg), .cnt_o(core_cnt), .en_o(core_en)
    );

    assign clk_out = pt_sel ? (src_clk & pt_gate) : div_out;

endmodule

// File: rtl/pds_checker.sv
`timescale 1ns/100ps
module pds_checker #(
    parameter int STEPS = 4,
    parameter int SW    = 3,
    parameter int LG_W  = 3,
    parameter int CNT_W = 6
) (
    input logic             src_clk,
    input logic             ref_clk,
    input logic             rst_n,
    input logic [SW-1:0]    step_q,
    input logic [LG_W-1:0]  lg_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             en_q,
    input logic             out_q
);

    p_step_range_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        int'(step_q) <= STEPS);

    p_step_single_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (step_q != $past(step_q)) |->
            ((step_q == SW'($past(step_q) + 1'b1)) || ($past(step_q) == SW'(step_q + 1'b1))));

    p_lg_range_r3: assert property (@(posedge src_clk) disable iff (!rst_n)
        int'(lg_q) <= 3 + STEPS);

    p_cnt_half_r2: assert property (@(posedge src_clk) disable iff (!rst_n)
        (lg_q != '0) |-> ((cnt_q >> (lg_q - 1'b1)) == '0));

    p_ratio_edge_r8: assert property (@(posedge src_clk) disable iff (!rst_n)
        (lg_q != $past(lg_q)) |-> (!$past(out_q) && cnt_q == '0));

    p_en_edge_r6: assert property (@(posedge src_clk) disable iff (!rst_n)
        (en_q != $past(en_q)) |-> !$past(out_q));

    p_off_low_r7: assert property (@(posedge src_clk) disable iff (!rst_n)
        !en_q |-> !out_q);

endmodule

bind pds_top pds_checker #(.STEPS(STEPS), .SW(SW), .LG_W(LG_W), .CNT_W(CNT_W)) i_chk (
    .src_clk(src_clk), .ref_clk(ref_clk), .rst_n(rst_n), .step_q(ref_step),
    .lg_q(core_lg), .cnt_q(core_cnt), .en_q(core_en), .out_q(div_out)
);

// File: tb/test_pds_top.sv
`timescale 1ns/100ps
module test_pds_top;

    localparam int PACE = 8;

    logic       src_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ratio_code = 2'b11;
    logic       pwr_down = 1'b0;
    logic       out_en = 1'b0;
    wire        clk_out;

    always #10 src_clk = ~src_clk;
    initial begin
        #3;
        forever #80 ref_clk = ~ref_clk;
    end

    pds_top #(.STEPS(4), .PACE_REF(PACE)) i_pds_top (
        .src_clk(src_clk), .ref_clk(ref_clk), .rst_n(rst_n),
        .ratio_code(ratio_code), .pwr_down(pwr_down), .out_en(out_en), .clk_out(clk_out)
    );

    int total = 0;
    int bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // edge, period and pulse-width monitors
    int      rises = 0;
    realtime last_rise = 0.0;
    realtime last_fall = 0.0;
    bit      log_on = 1'b0;
    int      nlog = 0;
    int      plog [256];
    realtime tlog [256];
    bit      mon_on = 1'b0;
    bit      mon_rise = 1'b0;
    bit      mon_fall = 1'b0;
    bit      lo_exact = 1'b0;
    int      wa = 0, wb = 0;
    int      hi_bad = 0, lo_bad = 0;
    int      pw;

    always @(posedge clk_out) begin
        if (log_on && nlog < 256) begin
            plog[nlog] = int'(($realtime - last_rise) / 20.0);
            tlog[nlog] = $realtime;
            nlog++;
        end
        if (mon_on && mon_fall) begin
            pw = int'($realtime - last_fall);
            if (lo_exact ? (pw != wa && pw != wb) : (pw < wa)) lo_bad++;
        end
        if (mon_on) mon_rise = 1'b1;
        last_rise = $realtime;
        rises++;
    end

    always @(negedge clk_out) begin
        if (mon_on && mon_rise) begin
            pw = int'($realtime - last_rise);
            if (pw != wa && pw != wb) hi_bad++;
        end
        if (mon_on) mon_fall = 1'b1;
        last_fall = $realtime;
    end

    task automatic start_mon(input int a, input int b, input bit exact);
        wa = a; wb = b; lo_exact = exact;
        hi_bad = 0; lo_bad = 0; mon_rise = 1'b0; mon_fall = 1'b0;
        mon_on = 1'b1;
    endtask

    // count rising edges and high samples over a window of w source cycles
    task automatic measure(input int p, input string req, input string tag);
        int w, r0, highs;
        w = (4 * p < 64) ? 64 : 4 * p;
        @(posedge clk_out);
        #2.5;
        r0 = rises;
        highs = 0;
        for (int i = 0; i < 4 * w; i++) begin
            if (clk_out) highs++;
            #5;
        end
        check(rises - r0 == w / p, req, {tag, " rising edges"}, rises - r0, w / p);
        check(highs == 2 * w, req, {tag, " high samples"}, highs, 2 * w);
    endtask

    task automatic low_window(input string req);
        int highs;
        highs = 0;
        for (int i = 0; i < 400; i++) begin
            #5;
            if (clk_out) highs++;
        end
        check(highs == 0, req, "output high while held off", highs, 0);
    endtask

    // analyse a logged step walk: base period b, up or down
    task automatic analyse(input int b, input bit up, input string tag);
        bit mono, legal;
        int seen, t_a, t_b, gap, va, vb, last;
        mono = 1'b1; legal = 1'b1; seen = 0; t_a = -1; t_b = -1;
        va = up ? 2 * b : 16 * b;
        vb = up ? 4 * b : 8 * b;
        for (int i = 0; i < nlog; i++) begin
            if (i > 0 && (up ? plog[i] < plog[i-1] : plog[i] > plog[i-1])) mono = 1'b0;
            case (plog[i] / b)
                1:  seen |= 1;
                2:  seen |= 2;
                4:  seen |= 4;
                8:  seen |= 8;
                16: seen |= 16;
                default: legal = 1'b0;
            endcase
            if (plog[i] * b > 0 && plog[i] % b != 0) legal = 1'b0;
            if (plog[i] == va && t_a < 0) t_a = int'(tlog[i]);
            if (plog[i] == vb && t_b < 0) t_b = int'(tlog[i]);
        end
        last = (nlog > 0) ? plog[nlog-1] : 0;
        gap = t_b - t_a;
        check(mono, "R4", {tag, " period series monotonic"}, int'(mono), 1);
        check(legal, "R8", {tag, " only whole-period values"}, int'(legal), 1);
        check(seen == 31, "R4", {tag, " all five factors seen"}, seen, 31);
        check(last == (up ? 16 * b : b), "R4", {tag, " final period"}, last, up ? 16 * b : b);
        check(t_a >= 0 && t_b >= 0 && gap >= 640 && gap <= 2560, "R5",
              {tag, " step spacing ns"}, gap, 1280);
    endtask

    initial begin
        int exp_p;
        #95;
        check(clk_out == 1'b0, "R7", "output low in reset", int'(clk_out), 0);
        #12 rst_n = 1'b1;
        #33 out_en = 1'b1;

        // R1 R2 R9: sweep of base codes
        for (int c = 0; c < 4; c++) begin
            ratio_code = 2'(c);
            exp_p = 1 << ((c + 1) % 4);
            #1000;
            measure(exp_p, (c == 3) ? "R9" : "R1 R2", $sformatf("code %0d", c));
        end

        // R3: settled power-down for each code
        pwr_down = 1'b1;
        #8000;
        for (int c = 0; c < 4; c++) begin
            ratio_code = 2'(c);
            exp_p = 16 * (1 << ((c + 1) % 4));
            #3000;
            measure(exp_p, "R3", $sformatf("pd code %0d", c));
        end
        pwr_down = 1'b0;
        #8000;

        // R4 R5: step walk in both directions from divide by 2
        ratio_code = 2'b00;
        #1000;
        nlog = 0; log_on = 1'b1;
        #7 pwr_down = 1'b1;
        #8000;
        log_on = 1'b0;
        analyse(2, 1'b1, "enter");
        nlog = 0; log_on = 1'b1;
        #13 pwr_down = 1'b0;
        #8000;
        log_on = 1'b0;
        analyse(2, 1'b0, "leave");

        // R6 R7: enable toggling at divide by 4
        ratio_code = 2'b01;
        #1000;
        start_mon(40, 40, 1'b0);
        out_en = 1'b0; #333;
        out_en = 1'b1; #517;
        out_en = 1'b0; #71;
        out_en = 1'b1; #289;
        out_en = 1'b0; #300;
        low_window("R7");
        out_en = 1'b1; #600;
        mon_on = 1'b0;
        check(hi_bad == 0, "R6", "shortened high pulses div4", hi_bad, 0);
        check(lo_bad == 0, "R6", "shortened low gaps div4", lo_bad, 0);

        // R6 R9: enable toggling in pass-through
        ratio_code = 2'b11;
        #600;
        start_mon(10, 10, 1'b0);
        out_en = 1'b0; #107;
        out_en = 1'b1; #253;
        out_en = 1'b0; #91;
        out_en = 1'b1; #300;
        mon_on = 1'b0;
        check(hi_bad == 0, "R6", "shortened high pulses div1", hi_bad, 0);
        check(lo_bad == 0, "R6", "shortened low gaps div1", lo_bad, 0);

        // R8: ratio changes mid-period between divide by 8 and by 2
        ratio_code = 2'b10;
        #1000;
        start_mon(80, 20, 1'b1);
        ratio_code = 2'b00; #337;
        ratio_code = 2'b10; #611;
        ratio_code = 2'b00; #143;
        ratio_code = 2'b10; #257;
        ratio_code = 2'b00; #500;
        mon_on = 1'b0;
        check(hi_bad == 0, "R8", "partial high pulses", hi_bad, 0);
        check(lo_bad == 0, "R8", "partial low gaps", lo_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule